// File: doc/BRIEF.md
# Low-Side Protection Fault Controller

This block sits between the PWM source and the three low-side gate drivers of a three-phase bridge. Every cycle it samples three digitised comparator flags: DC-link overcurrent, DC-link short circuit and control-supply undervoltage. While no fault is active, the low-side ON commands pass to the gate enables with one register of delay. The high-side commands never pass through this block.

The block treats a flag as a fault only after it has stayed high for a set number of consecutive clock cycles. Overcurrent, short circuit and undervoltage each have their own count. When an overcurrent or short circuit is confirmed, all three gate enables drop together. The active-low fault output then goes low for a fixed number of cycles. After that pulse the gates stay blocked until the commands show all three low-side switches OFF in the same cycle.

A confirmed undervoltage works differently. It holds the fault output low and the gates off for as long as the flag stays high, and it releases both without waiting for an OFF command. All durations are parameters in clock cycles. The supply hysteresis belongs to the analog comparator that produces the undervoltage flag.

Top module: `lowside_fault_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `fault_n` is 1 and `lo_gate` is 3'b000.
- R2: With no fault active, `lo_gate` equals the value `lo_cmd` had at the previous rising clock edge. Bit i of both buses is phase leg i.
- R3: Suppose `oc_flag` is sampled high on OC_FILT consecutive edges. On the next edge, `fault_n` goes to 0 and all three `lo_gate` bits go to 0.
- R4: If `oc_flag` stays high for fewer than OC_FILT consecutive edges, no trip occurs. Any low sample restarts the count from zero.
- R5: Suppose `sc_flag` is sampled high on SC_FILT consecutive edges. On the next edge, `fault_n` goes to 0 and `lo_gate` goes to 0. Shorter runs of `sc_flag` cause no trip.
- R6: After an overcurrent or short-circuit trip, `fault_n` stays 0 for exactly PULSE_LEN cycles and then returns to 1.
- R7: After the pulse ends, `lo_gate` stays 3'b000 while any `lo_cmd` bit is 1. Once `lo_cmd` is sampled as 3'b000, `lo_gate` follows `lo_cmd` again from the next cycle.
- R8: A further overcurrent or short-circuit qualification during an active pulse neither restarts nor lengthens the pulse.
- R9: Suppose `uv_flag` is sampled high on UV_FILT consecutive edges. On the next edge, `fault_n` goes to 0 and `lo_gate` goes to 0, and both stay that way while `uv_flag` remains high.
- R10: Once `uv_flag` is sampled low, the undervoltage fault releases two edges later. `fault_n` returns to 1 and `lo_gate` follows `lo_cmd` again without needing an OFF command.
- R11: If `uv_flag` stays high for fewer than UV_FILT consecutive edges, the fault output and the gates are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lo_cmd | input | 3 | Low-side ON commands, one bit per leg |
| oc_flag | input | 1 | Overcurrent comparator flag, synchronised |
| sc_flag | input | 1 | Short-circuit comparator flag, synchronised |
| uv_flag | input | 1 | Control-supply undervoltage flag, synchronised |
| lo_gate | output | 3 | Gated low-side enables, registered |
| fault_n | output | 1 | Active-low fault indication, registered |

## Verification
The bench runs a short configuration and sweeps every flag burst length from one cycle up to each filter length. An off-by-one filter would trip one cycle early, or fail to trip at the exact threshold. It also sends two sub-threshold overcurrent bursts separated by a single low cycle. A filter that does not clear its count would add the two bursts and trip on them.

The bench counts the fault pulse cycle by cycle, and it counts it again while a second overcurrent qualifies during the pulse. A retriggering timer would give a longer pulse. It also drives partial OFF patterns before a full OFF. A controller that releases on any OFF bit, or right at the end of the pulse, would re-enable a gate too early.

The undervoltage sequence changes the commands while the fault is held. It then checks that release needs no OFF command. A design that shared the pulse logic with undervoltage would release after PULSE_LEN cycles or would wait for an OFF command.

// File: rtl/lsf_pkg.sv
package lsf_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_PULSE = 2'd1,
    ST_HOLD  = 2'd2
  } trip_st_e;

  localparam int SRC_OC = 0;
  localparam int SRC_SC = 1;
  localparam int SRC_UV = 2;
  localparam int NUM_SRC = 3;
endpackage

// File: rtl/persist_filter.sv
module persist_filter #(
  parameter int LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic flag_i,
  output logic qual_o
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LIMIT = CW'(LEN);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || !flag_i) begin
      run_q <= '0;
    end else if (run_q != LIMIT) begin
      run_q <= run_q + 1'b1;
    end
  end

  assign qual_o = (run_q == LIMIT);
endmodule

// File: rtl/trip_sequencer.sv
module trip_sequencer
  import lsf_pkg::*;
#(
  parameter int PULSE_LEN = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     trip_i,
  input  logic     all_off_i,
  output trip_st_e st_q,
  output trip_st_e st_nxt
);
  localparam int PW = (PULSE_LEN > 2) ? $clog2(PULSE_LEN) : 1;
  localparam logic [PW-1:0] LAST = PW'(PULSE_LEN - 1);

  logic [PW-1:0] pcnt_q, pcnt_nxt;

  always_comb begin
    st_nxt   = st_q;
    pcnt_nxt = pcnt_q;
    unique case (st_q)
      ST_RUN: begin
        if (trip_i) begin
          st_nxt   = ST_PULSE;
          pcnt_nxt = '0;
        end
      end
      ST_PULSE: begin
        if (pcnt_q == LAST) st_nxt = ST_HOLD;
        else                pcnt_nxt = pcnt_q + 1'b1;
      end
      ST_HOLD: begin
        if (all_off_i) st_nxt = ST_RUN;
      end
      default: st_nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_RUN;
      pcnt_q <= '0;
    end else begin
      st_q   <= st_nxt;
      pcnt_q <= pcnt_nxt;
    end
  end
endmodule

// File: rtl/lowside_fault_ctrl.sv
module lowside_fault_ctrl
  import lsf_pkg::*;
#(
  parameter int NUM_LEG   = 3,
  parameter int OC_FILT   = 1000,
  parameter int SC_FILT   = 200,
  parameter int UV_FILT   = 1000,
  parameter int PULSE_LEN = 180000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_LEG-1:0] lo_cmd,
  input  logic               oc_flag,
  input  logic               sc_flag,
  input  logic               uv_flag,
  output logic [NUM_LEG-1:0] lo_gate,
  output logic               fault_n
);
  localparam int FILT_LEN [NUM_SRC] = '{OC_FILT, SC_FILT, UV_FILT};

  logic [NUM_SRC-1:0] raw;
  logic [NUM_SRC-1:0] qual;
  trip_st_e           st_q, st_nxt;
  logic               uv_q;
  logic [NUM_LEG-1:0] gate_nxt;
  logic               fault_nxt;

  assign raw[SRC_OC] = oc_flag;
  assign raw[SRC_SC] = sc_flag;
  assign raw[SRC_UV] = uv_flag;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_filt
    persist_filter #(.LEN(FILT_LEN[g])) u_filt (
      .clk    (clk),
      .rst    (rst),
      .flag_i (raw[g]),
      .qual_o (qual[g])
    );
  end

  assign uv_q = qual[SRC_UV];

  trip_sequencer #(.PULSE_LEN(PULSE_LEN)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .trip_i    (qual[SRC_OC] | qual[SRC_SC]),
    .all_off_i (lo_cmd == '0),
    .st_q      (st_q),
    .st_nxt    (st_nxt)
  );

  always_comb begin
    gate_nxt  = (st_nxt == ST_RUN && !uv_q) ? lo_cmd : '0;
    fault_nxt = (st_nxt == ST_PULSE) || uv_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_gate <= '0;
      fault_n <= 1'b1;
    end else begin
      lo_gate <= gate_nxt;
      fault_n <= !fault_nxt;
    end
  end
endmodule

// File: rtl/lsf_checker.sv
module lsf_checker
  import lsf_pkg::*;
#(
  parameter int NUM_LEG   = 3,
  parameter int PULSE_LEN = 180000
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_LEG-1:0] lo_cmd,
  input logic [NUM_LEG-1:0] lo_gate,
  input logic               fault_n,
  input trip_st_e           st_q,
  input logic [NUM_SRC-1:0] qual
);
  localparam int LW = $clog2(PULSE_LEN + 2) + 1;
  logic [LW-1:0] low_run;

  always_ff @(posedge clk) begin
    if (rst || fault_n || qual[SRC_UV]) low_run <= '0;
    else if (low_run != {LW{1'b1}})     low_run <= low_run + 1'b1;
  end

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (fault_n && lo_gate == '0));

  p_gates_off_fault_r3: assert property (@(posedge clk) disable iff (rst)
    !fault_n |-> lo_gate == '0);

  p_sc_trip_r5: assert property (@(posedge clk) disable iff (rst)
    (qual[SRC_SC] && st_q == ST_RUN) |=> !fault_n);

  p_pulse_width_r6: assert property (@(posedge clk) disable iff (rst)
    low_run <= LW'(PULSE_LEN));

  p_hold_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HOLD && lo_cmd != '0) |=> lo_gate == '0);

  p_uv_fault_r9: assert property (@(posedge clk) disable iff (rst)
    qual[SRC_UV] |=> (!fault_n && lo_gate == '0));
endmodule

bind lowside_fault_ctrl lsf_checker #(
  .NUM_LEG   (NUM_LEG),
  .PULSE_LEN (PULSE_LEN)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .lo_cmd  (lo_cmd),
  .lo_gate (lo_gate),
  .fault_n (fault_n),
  .st_q    (st_q),
  .qual    (qual)
);

// File: tb/lowside_fault_ctrl_tb.sv
module lowside_fault_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int OC_N  = 6;
  localparam int SC_N  = 3;
  localparam int UV_N  = 5;
  localparam int PL    = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] lo_cmd = '0;
  logic       oc_flag = 1'b0, sc_flag = 1'b0, uv_flag = 1'b0;
  logic [2:0] lo_gate;
  logic       fault_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lowside_fault_ctrl #(
    .NUM_LEG(3), .OC_FILT(OC_N), .SC_FILT(SC_N), .UV_FILT(UV_N), .PULSE_LEN(PL)
  ) u_dut (
    .clk(clk), .rst(rst), .lo_cmd(lo_cmd), .oc_flag(oc_flag),
    .sc_flag(sc_flag), .uv_flag(uv_flag), .lo_gate(lo_gate), .fault_n(fault_n)
  );

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk_out(input string req, input logic exp_f, input logic [2:0] exp_g);
    n_chk++;
    if (fault_n !== exp_f || lo_gate !== exp_g) begin
      n_fail++;
      $display("FAIL %s: fault_n=%b lo_gate=%b, expected fault_n=%b lo_gate=%b",
               req, fault_n, lo_gate, exp_f, exp_g);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d, expected %0d", req, act, exp);
    end
  endtask

  // Fault output is low at entry; measures pulse, then walks release (R6, R7)
  task automatic pulse_and_release(input string tag);
    int w;
    w = 1;
    for (int i = 0; i < 4 * PL; i++) begin
      tick(1);
      if (fault_n) break;
      w++;
    end
    chk_int({"R6 pulse width ", tag}, w, PL);
    chk_out("R7 held after pulse", 1'b1, 3'b000);
    lo_cmd = 3'b011; tick(2);
    chk_out("R7 partial off keeps block", 1'b1, 3'b000);
    lo_cmd = 3'b000; tick(1);
    chk_out("R7 all off releases", 1'b1, 3'b000);
    lo_cmd = 3'b101; tick(1);
    chk_out("R7 follows after release", 1'b1, 3'b101);
  endtask

  initial begin
    tick(3);
    chk_out("R1 in reset", 1'b1, 3'b000);
    rst = 1'b0;
    tick(1);
    chk_out("R1 after reset", 1'b1, 3'b000);

    for (int c = 0; c < 8; c++) begin
      lo_cmd = 3'(c); tick(1);
      chk_out("R2 pass-through", 1'b1, 3'(c));
    end

    for (int l = 1; l <= OC_N; l++) begin
      lo_cmd = 3'b111; tick(1);
      oc_flag = 1'b1; tick(l);
      oc_flag = 1'b0;
      if (l == OC_N) chk_out("R3 no trip before qualify edge", 1'b1, 3'b111);
      tick(1);
      if (l < OC_N) chk_out("R4 short OC burst", 1'b1, 3'b111);
      else begin
        chk_out("R3 OC trip", 1'b0, 3'b000);
        pulse_and_release("oc");
      end
    end

    lo_cmd = 3'b110; tick(1);
    oc_flag = 1'b1; tick(OC_N - 1);
    oc_flag = 1'b0; tick(1);
    oc_flag = 1'b1; tick(OC_N - 1);
    oc_flag = 1'b0; tick(2);
    chk_out("R4 count restarts", 1'b1, 3'b110);

    for (int l = 1; l <= SC_N; l++) begin
      lo_cmd = 3'b111; tick(1);
      sc_flag = 1'b1; tick(l);
      sc_flag = 1'b0; tick(1);
      if (l < SC_N) chk_out("R5 short SC burst", 1'b1, 3'b111);
      else begin
        chk_out("R5 SC trip", 1'b0, 3'b000);
        pulse_and_release("sc");
      end
    end

    begin
      int w;
      lo_cmd = 3'b111; tick(1);
      sc_flag = 1'b1; tick(SC_N);
      sc_flag = 1'b0; tick(1);
      chk_out("R8 trip before retrigger", 1'b0, 3'b000);
      oc_flag = 1'b1;
      w = 1;
      for (int i = 0; i < 4 * PL; i++) begin
        tick(1);
        if (i == OC_N) oc_flag = 1'b0;
        if (fault_n) break;
        w++;
      end
      oc_flag = 1'b0;
      chk_int("R8 no retrigger width", w, PL);
      lo_cmd = 3'b000; tick(1);
      lo_cmd = 3'b111; tick(1);
      chk_out("R8 recovered", 1'b1, 3'b111);
    end

    for (int l = 1; l < UV_N; l++) begin
      uv_flag = 1'b1; tick(l);
      uv_flag = 1'b0; tick(1);
      chk_out("R11 short UV glitch", 1'b1, 3'b111);
    end

    begin
      int lowc;
      uv_flag = 1'b1; tick(UV_N);
      chk_out("R9 no UV fault before qualify", 1'b1, 3'b111);
      tick(1);
      chk_out("R9 UV fault", 1'b0, 3'b000);
      lo_cmd = 3'b010;
      lowc = 0;
      for (int i = 0; i < 3 * PL; i++) begin
        tick(1);
        if (!fault_n && lo_gate == 3'b000) lowc++;
      end
      chk_int("R9 UV held", lowc, 3 * PL);
      uv_flag = 1'b0; tick(1);
      chk_out("R10 still held one edge", 1'b0, 3'b000);
      tick(1);
      chk_out("R10 UV release without OFF", 1'b1, 3'b010);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule